// File: doc/BRIEF.md
# Asymmetric-Step Loadable Up/Down Counter

A fully synchronous nine-bit counter. Each clock edge it does exactly one of four things: it clears itself, takes a parallel value, steps up by three, or steps down by five. When nothing is enabled it holds. The count wraps modulo 512. A pair of registered flags reports the cycle just after a step that left the nine-bit range, either past the top or below zero.

The count drives a parity output that makes the ten bits {count, parity} carry an even number of ones. Step sizes and width are parameters. The defaults give the 9-bit, +3/−5 arrangement.

The wrap flags are held in a three-state machine, and the brief uses its state names:
- `FLG_CLEAR`: no flag raised.
- `FLG_CARRY`: carry high.
- `FLG_BORROW`: borrow high.

Transitions out of any state:
- To `FLG_CARRY` on an up step whose true sum is at least 512.
- To `FLG_BORROW` on a down step from a count below 5.
- To `FLG_CLEAR` on reset, load, an idle cycle or a step that does not wrap.

Top module: `step_counter9`

## Requirements
- R1: `parity` equals the XOR of the nine `count` bits. The ten bits {count, parity} therefore always hold an even number of ones, for the count currently in the register.
- R2: On a clock edge with `rst` high, `count` becomes 0 and `carry` and `borrow` become 0. This holds whatever `load_en` and `cnt_en` are.
- R3: On an edge with `rst` low and `load_en` high, `count` takes `load_val`, both flags clear and `cnt_en` is ignored.
- R4: On an edge with `rst` and `load_en` low, `cnt_en` high and `up_sel` high, `count` becomes (count + 3) mod 512.
- R5: On an edge with `rst` and `load_en` low, `cnt_en` high and `up_sel` low, `count` becomes (count − 5) mod 512.
- R6: On an edge with `rst`, `load_en` and `cnt_en` all low, `count` holds its value and both flags clear.
- R7: `carry` is 1 for exactly the cycle after an up step taken from a count of 509 or more (state `FLG_CARRY`). Otherwise it is 0.
- R8: `borrow` is 1 for exactly the cycle after a down step taken from a count of 4 or less (state `FLG_BORROW`). Otherwise it is 0.
- R9: `carry` and `borrow` are never 1 together. A flag drops after one cycle, even when the next step is in the same direction but does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every update happens on its rising edge |
| rst | input | 1 | Synchronous reset, active high, highest priority |
| load_en | input | 1 | Parallel load enable |
| load_val | input | 9 | Value taken on a load |
| cnt_en | input | 1 | Step enable |
| up_sel | input | 1 | 1 = step up by 3, 0 = step down by 5 |
| count | output | 9 | Registered count |
| parity | output | 1 | Even-parity bit over `count` |
| carry | output | 1 | Registered overflow flag for the previous step |
| borrow | output | 1 | Registered underflow flag for the previous step |

## Verification
The hardest cases to reach are the exact wrap boundaries. An up step from 508 must not raise carry, while one from 509 must. A down step from 5 must not raise borrow, while one from 4 must. Free counting from reset reaches these values only after long and irregular walks, so the bench loads each neighbour of a boundary directly and then takes one step. It then takes a second, non-wrapping step in the same direction to show that the flag falls.

// File: rtl/step_counter9_pkg.sv
package step_counter9_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_UP   = 2'd2,
        OP_DOWN = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        FLG_CLEAR  = 2'd0,
        FLG_CARRY  = 2'd1,
        FLG_BORROW = 2'd2
    } flag_state_e;

endpackage

// File: rtl/step_op_decode.sv
module step_op_decode
    import step_counter9_pkg::*;
(
    input  logic load_en,
    input  logic cnt_en,
    input  logic up_sel,
    output op_e  op
);

    // load outranks stepping; reset is handled at the register
    always_comb begin
        if (load_en)
            op = OP_LOAD;
        else if (cnt_en && up_sel)
            op = OP_UP;
        else if (cnt_en)
            op = OP_DOWN;
        else
            op = OP_HOLD;
    end

endmodule

// File: rtl/step_next_value.sv
module step_next_value
    import step_counter9_pkg::*;
#(
    parameter int WIDTH   = 9,
    parameter int UP_STEP = 3,
    parameter int DN_STEP = 5
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] load_val,
    input  op_e              op,
    output logic [WIDTH-1:0] nxt,
    output logic             wrap_up,
    output logic             wrap_dn
);

    localparam int EXT = WIDTH + 1;

    logic [EXT-1:0] up_sum;
    logic [EXT-1:0] dn_diff;

    // one extra bit holds the carry-out / borrow-out
    assign up_sum  = {1'b0, cur} + EXT'(UP_STEP);
    assign dn_diff = {1'b0, cur} - EXT'(DN_STEP);

    always_comb begin
        nxt     = cur;
        wrap_up = 1'b0;
        wrap_dn = 1'b0;
        unique case (op)
            OP_LOAD: nxt = load_val;
            OP_UP: begin
                nxt     = up_sum[WIDTH-1:0];
                wrap_up = up_sum[WIDTH];
            end
            OP_DOWN: begin
                nxt     = dn_diff[WIDTH-1:0];
                wrap_dn = dn_diff[WIDTH];
            end
            OP_HOLD: nxt = cur;
        endcase
    end

endmodule

// File: rtl/even_parity_gen.sv
module even_parity_gen #(
    parameter int WIDTH = 9
) (
    input  logic [WIDTH-1:0] data,
    output logic             parity
);

    logic [WIDTH-1:0] chain;

    assign chain[0] = data[0];

    generate
        for (genvar i = 1; i < WIDTH; i++) begin : g_xor
            assign chain[i] = chain[i-1] ^ data[i];
        end
    endgenerate

    assign parity = chain[WIDTH-1];

endmodule

// File: rtl/step_counter9.sv
module step_counter9
    import step_counter9_pkg::*;
#(
    parameter int WIDTH   = 9,
    parameter int UP_STEP = 3,
    parameter int DN_STEP = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_val,
    input  logic             cnt_en,
    input  logic             up_sel,
    output logic [WIDTH-1:0] count,
    output logic             parity,
    output logic             carry,
    output logic             borrow
);

    op_e              op;
    logic [WIDTH-1:0] count_q;
    logic [WIDTH-1:0] count_d;
    logic             wrap_up;
    logic             wrap_dn;
    flag_state_e      flag_q;
    flag_state_e      flag_d;

    step_op_decode u_decode (
        .load_en (load_en),
        .cnt_en  (cnt_en),
        .up_sel  (up_sel),
        .op      (op)
    );

    step_next_value #(
        .WIDTH   (WIDTH),
        .UP_STEP (UP_STEP),
        .DN_STEP (DN_STEP)
    ) u_next (
        .cur      (count_q),
        .load_val (load_val),
        .op       (op),
        .nxt      (count_d),
        .wrap_up  (wrap_up),
        .wrap_dn  (wrap_dn)
    );

    even_parity_gen #(
        .WIDTH (WIDTH)
    ) u_parity (
        .data   (count_q),
        .parity (parity)
    );

    // flag transitions: any state moves on each edge by the step outcome
    always_comb begin
        if (wrap_up)
            flag_d = FLG_CARRY;
        else if (wrap_dn)
            flag_d = FLG_BORROW;
        else
            flag_d = FLG_CLEAR;
    end

    // state and count registers
    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            flag_q  <= FLG_CLEAR;
        end else begin
            count_q <= count_d;
            flag_q  <= flag_d;
        end
    end

    // outputs from state
    always_comb begin
        carry  = 1'b0;
        borrow = 1'b0;
        unique case (flag_q)
            FLG_CLEAR:  ;
            FLG_CARRY:  carry  = 1'b1;
            FLG_BORROW: borrow = 1'b1;
            default:    ;
        endcase
    end

    assign count = count_q;

endmodule

// File: rtl/step_counter9_checker.sv
module step_counter9_checker #(
    parameter int WIDTH   = 9,
    parameter int UP_STEP = 3,
    parameter int DN_STEP = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             load_en,
    input logic [WIDTH-1:0] load_val,
    input logic             cnt_en,
    input logic             up_sel,
    input logic [WIDTH-1:0] count,
    input logic             parity,
    input logic             carry,
    input logic             borrow
);

    localparam logic [WIDTH-1:0] UP_W     = WIDTH'(UP_STEP);
    localparam logic [WIDTH-1:0] DN_W     = WIDTH'(DN_STEP);
    localparam logic [WIDTH-1:0] UP_LIMIT = WIDTH'((2 ** WIDTH) - UP_STEP);

    logic rst_prev_q = 1'b0;
    logic seen_rst_q = 1'b0;

    logic go_up;
    logic go_dn;
    logic idle;

    assign go_up = !load_en && cnt_en && up_sel;
    assign go_dn = !load_en && cnt_en && !up_sel;
    assign idle  = !load_en && !cnt_en;

    always_ff @(posedge clk) begin
        rst_prev_q <= rst;
        if (rst)
            seen_rst_q <= 1'b1;
        if (rst_prev_q) begin
            a_r2_reset_state: assert (count == '0 && !carry && !borrow)
                else $error("R2 reset state wrong");
        end
        if (seen_rst_q) begin
            a_r1_even_parity: assert ((^{count, parity}) == 1'b0)
                else $error("R1 parity wrong");
        end
    end

    a_r3_load: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (count == $past(load_val) && !carry && !borrow));

    a_r4_step_up: assert property (@(posedge clk) disable iff (rst)
        go_up |=> (count == $past(count) + UP_W));

    a_r5_step_down: assert property (@(posedge clk) disable iff (rst)
        go_dn |=> (count == $past(count) - DN_W));

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        idle |=> ($stable(count) && !carry && !borrow));

    a_r7_carry_set: assert property (@(posedge clk) disable iff (rst)
        (go_up && count >= UP_LIMIT) |=> carry);

    a_r7_carry_clear: assert property (@(posedge clk) disable iff (rst)
        !(go_up && count >= UP_LIMIT) |=> !carry);

    a_r8_borrow_set: assert property (@(posedge clk) disable iff (rst)
        (go_dn && count < DN_W) |=> borrow);

    a_r8_borrow_clear: assert property (@(posedge clk) disable iff (rst)
        !(go_dn && count < DN_W) |=> !borrow);

    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(carry && borrow));

endmodule

bind step_counter9 step_counter9_checker #(
    .WIDTH   (WIDTH),
    .UP_STEP (UP_STEP),
    .DN_STEP (DN_STEP)
) u_checker (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .load_val (load_val),
    .cnt_en   (cnt_en),
    .up_sel   (up_sel),
    .count    (count),
    .parity   (parity),
    .carry    (carry),
    .borrow   (borrow)
);

// File: tb/test_step_counter9.sv
module test_step_counter9;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 9;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_en = 1'b0;
    logic [W-1:0] load_val = '0;
    logic         cnt_en = 1'b0;
    logic         up_sel = 1'b0;
    logic [W-1:0] count;
    logic         parity;
    logic         carry;
    logic         borrow;

    int vectors     = 0;
    int miscompares = 0;

    // reference model state
    int exp_count  = 0;
    bit exp_carry  = 0;
    bit exp_borrow = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    step_counter9 i_step_counter9 (
        .clk      (clk),
        .rst      (rst),
        .load_en  (load_en),
        .load_val (load_val),
        .cnt_en   (cnt_en),
        .up_sel   (up_sel),
        .count    (count),
        .parity   (parity),
        .carry    (carry),
        .borrow   (borrow)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // one clock with the given inputs; model updated from the requirements
    task automatic apply(input bit r, input bit ld, input int lv, input bit en, input bit up,
                         input string req);
        int t;
        @(negedge clk);
        rst = r; load_en = ld; load_val = W'(lv); cnt_en = en; up_sel = up;
        if (r) begin
            exp_count = 0; exp_carry = 0; exp_borrow = 0;
        end else if (ld) begin
            exp_count = lv; exp_carry = 0; exp_borrow = 0;
        end else if (en && up) begin
            t = exp_count + 3;
            exp_carry = (t > 511); exp_borrow = 0; exp_count = t % 512;
        end else if (en) begin
            t = exp_count - 5;
            exp_borrow = (t < 0); exp_carry = 0; exp_count = (t + 512) % 512;
        end else begin
            exp_carry = 0; exp_borrow = 0;
        end
        @(posedge clk);
        #1;
        check(req, "count", int'(count), exp_count);
        check(req, "carry", int'(carry), int'(exp_carry));
        check(req, "borrow", int'(borrow), int'(exp_borrow));
        check("R1", "parity", int'(parity), int'(^W'(exp_count)));
    endtask

    task automatic t_reset;
        apply(1, 0, 0, 0, 0, "R2");
        apply(0, 1, 300, 0, 0, "R3");
        apply(1, 1, 77, 1, 1, "R2");   // reset wins over load and enable
        apply(0, 1, 4, 0, 0, "R3");
        apply(0, 0, 0, 1, 0, "R8");    // borrow raised
        apply(1, 0, 0, 1, 0, "R2");    // reset clears borrow and count
    endtask

    task automatic t_load;
        apply(0, 1, 511, 1, 1, "R3");  // enable ignored while loading
        apply(0, 1, 0, 1, 0, "R3");
        apply(0, 1, 170, 0, 0, "R3");
        apply(0, 1, 341, 1, 0, "R3");
    endtask

    task automatic t_up;
        apply(0, 1, 100, 0, 0, "R3");
        for (int i = 0; i < 6; i++) apply(0, 0, 0, 1, 1, "R4");
    endtask

    task automatic t_down;
        apply(0, 1, 200, 0, 0, "R3");
        for (int i = 0; i < 6; i++) apply(0, 0, 0, 1, 0, "R5");
    endtask

    task automatic t_hold;
        apply(0, 1, 509, 0, 0, "R3");
        apply(0, 0, 0, 1, 1, "R7");    // wrap to 0 with carry
        apply(0, 0, 123, 0, 1, "R6");  // idle clears carry, count holds
        apply(0, 0, 0, 0, 0, "R6");
    endtask

    task automatic t_carry_edges;
        apply(0, 1, 508, 0, 0, "R3");
        apply(0, 0, 0, 1, 1, "R7");    // 511, no carry
        apply(0, 0, 0, 1, 1, "R7");    // 2, carry
        apply(0, 0, 0, 1, 1, "R9");    // 5, carry drops
        apply(0, 1, 510, 0, 0, "R3");
        apply(0, 0, 0, 1, 1, "R7");    // 1, carry
        apply(0, 1, 511, 0, 0, "R3");  // load clears carry
        apply(0, 0, 0, 1, 1, "R7");    // 2, carry
        apply(0, 0, 0, 1, 0, "R9");    // 509, borrow replaces carry
    endtask

    task automatic t_borrow_edges;
        apply(0, 1, 5, 0, 0, "R3");
        apply(0, 0, 0, 1, 0, "R8");    // 0, no borrow
        apply(0, 0, 0, 1, 0, "R8");    // 507, borrow
        apply(0, 0, 0, 1, 0, "R9");    // 502, borrow drops
        apply(0, 1, 4, 0, 0, "R3");
        apply(0, 0, 0, 1, 0, "R8");    // 511, borrow
        apply(0, 0, 0, 1, 1, "R9");    // 2, carry replaces borrow
    endtask

    task automatic t_mixed;
        for (int i = 0; i < 400; i++)
            apply(0, (i % 37) == 36, (i * 53) % 512, (i % 7) != 3, (i % 3) != 0, "R4");
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : main
        t_reset();
        t_load();
        t_up();
        t_down();
        t_hold();
        t_carry_edges();
        t_borrow_edges();
        t_mixed();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule